// File: doc/BRIEF.md
# Cable Fault Echo Timer

This block measures how long a transmitting station hears its own carrier before that carrier is lost or a collision is seen. A short time points to a nearby fault, such as an open or shorted cable end. A long time points to a fault further away. The count advances only on cycles where a 10 MHz enable pulse is present. Each count step is therefore 100 ns of elapsed time.

The controller sequencer clears the counter before a frame and then raises its transmit-active flag. Counting begins once the synchronized carrier is seen during the transmission. Counting stops for good, for that transmission, when collision appears or carrier goes away. When the transmit flag drops, a one-cycle strobe marks the frozen value as ready, so it can be written back with the frame status. The carrier and collision inputs are asynchronous and are each passed through a flop chain before use. The counter saturates at all ones rather than wrapping.

Top module: `fault_echo_timer`

## Requirements
- R1: After reset `count_o` is 0 and `valid_o` is 0.
- R2: While `tx_active_i` is high and the synchronized carrier is high with no synchronized collision, `count_o` rises by exactly one on each clock edge where `tick_i` is high. Carrier and collision each see a two-cycle synchronizer delay. Holding carrier for K clock edges with `tick_i` high throughout therefore adds K.
- R3: Once the synchronized carrier falls, `count_o` stops changing for the rest of that transmission.
- R4: Once the synchronized collision rises, `count_o` stops changing. If collision and carrier arrive together, nothing is counted.
- R5: After counting has stopped within a transmission, it does not resume in that transmission, even if carrier returns.
- R6: At 1023 (all ones, 10 bits) the count holds and never wraps to zero.
- R7: A high `clear_i` sets `count_o` to 0 on the next edge. This takes priority over a count step in the same cycle. Counting then continues if the measurement is still running.
- R8: Nothing but `clear_i` changes a held value. The value survives the end of a transmission, idle time and the start of a new transmission.
- R9: `valid_o` is high for exactly one cycle: the cycle after the first edge at which `tx_active_i` is sampled low following a transmission. During that cycle `count_o` holds the final value.
- R10: With `tx_active_i` low, carrier activity does not change `count_o`.
- R11: On edges where `tick_i` is low, `count_o` does not change unless cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | 10 MHz count enable pulse |
| tx_active_i | input | 1 | Transmission in progress (synchronous) |
| carrier_i | input | 1 | Carrier sense, asynchronous |
| collision_i | input | 1 | Collision detect, asynchronous |
| clear_i | input | 1 | Synchronous clear of the count |
| count_o | output | 10 | Measured time in ticks, saturating |
| valid_o | output | 1 | One-cycle strobe after transmission ends |

## Verification
The sequencer state is the main hidden state. If it wrongly stays in the running state after a carrier drop or a collision, `count_o` keeps moving on the very next tick. If carrier is later reasserted in the same transmission, the error shows as a count above the expected value. A counter that wraps shows as a small value within one tick of passing 1023. A stuck or repeated transmit-end flag shows on `valid_o` in the first or second cycle after `tx_active_i` falls. A clear that loses to a tick shows as 1 instead of 0 on the edge right after the clear.

// File: rtl/fet_pkg.sv
package fet_pkg;
   typedef enum logic [1:0] {
      FET_IDLE    = 2'd0,
      FET_ARMED   = 2'd1,
      FET_RUNNING = 2'd2,
      FET_FROZEN  = 2'd3
   } fet_state_e;
endpackage

// File: rtl/fet_sync.sv
module fet_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("fet_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[LAST];
endmodule

// File: rtl/fet_ctrl.sv
module fet_ctrl
   import fet_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic tx_active_i,
   input  logic car_s_i,
   input  logic col_s_i,
   output logic step_o,
   output logic done_o
);
   fet_state_e st_q, st_d;
   logic       live;
   logic       done_q;

   assign live = tx_active_i & car_s_i & ~col_s_i &
                 ((st_q == FET_ARMED) | (st_q == FET_RUNNING));

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         FET_IDLE:    if (tx_active_i) st_d = FET_ARMED;
         FET_ARMED: begin
            if (!tx_active_i)               st_d = FET_IDLE;
            else if (live)                  st_d = FET_RUNNING;
            else if (car_s_i && col_s_i)    st_d = FET_FROZEN;
         end
         FET_RUNNING: begin
            if (!tx_active_i) st_d = FET_IDLE;
            else if (!live)   st_d = FET_FROZEN;
         end
         FET_FROZEN:  if (!tx_active_i) st_d = FET_IDLE;
         default:     st_d = FET_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FET_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q != FET_IDLE) & ~tx_active_i;
      end
   end

   assign step_o = live & tick_i;
   assign done_o = done_q;

   // R5
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FET_FROZEN) |=> (st_q == FET_FROZEN || st_q == FET_IDLE));

   // R9
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/fet_counter.sv
module fet_counter #(
   parameter int WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [WIDTH-1:0] value_o
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clear_i)                cnt_q <= '0;
      else if (step_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign value_o = cnt_q;

   // R6
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> cnt_q >= $past(cnt_q));

   // R7
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> cnt_q == '0);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fault_echo_timer.sv
module fault_echo_timer #(
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             tx_active_i,
   input  logic             carrier_i,
   input  logic             collision_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] count_o,
   output logic             valid_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("fault_echo_timer: CNT_W must be at least 2");
   end

   logic [1:0] sync_bus;
   logic       car_s, col_s, step;

   fet_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({collision_i, carrier_i}),
      .sync_o  (sync_bus)
   );
   assign car_s = sync_bus[0];
   assign col_s = sync_bus[1];

   fet_ctrl ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .tx_active_i (tx_active_i),
      .car_s_i     (car_s),
      .col_s_i     (col_s),
      .step_o      (step),
      .done_o      (valid_o)
   );

   fet_counter #(.WIDTH(CNT_W)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_i),
      .step_i  (step),
      .value_o (count_o)
   );

   // R4
   collision_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_s && !clear_i) |=> $stable(count_o));

   // R10
   no_tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_active_i && !clear_i) |=> $stable(count_o));
endmodule

// File: tb/fault_echo_timer_tb.sv
module fault_echo_timer_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, tx = 1'b0, car = 1'b0, col = 1'b0, clr = 1'b0;
   logic [9:0] count;
   logic       valid;
   int         n_checks = 0;
   int         n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fault_echo_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .tx_active_i(tx),
      .carrier_i(car), .collision_i(col), .clear_i(clr),
      .count_o(count), .valid_o(valid)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_clear();
      clr = 1'b1; step(1); clr = 1'b0;
   endtask

   task automatic end_tx(input int exp_cnt, input string req);
      tx = 1'b0; car = 1'b0; col = 1'b0;
      step(1);
      chk({req, " valid strobe"}, valid, 1);
      chk({req, " final count"}, count, exp_cnt);
      step(1);
      chk({req, " strobe single"}, valid, 0);
      step(3);
   endtask

   task automatic t_reset();
      chk("R1 count", count, 0);
      chk("R1 valid", valid, 0);
   endtask

   task automatic t_no_tx();
      // R10: carrier with no transmission
      tick = 1'b1; car = 1'b1; step(12); car = 1'b0; step(4);
      chk("R10 idle carrier", count, 0);
   endtask

   task automatic t_carrier_drop();
      do_clear(); tx = 1'b1; step(3);
      chk("R2 no carrier yet", count, 0);
      car = 1'b1; step(40); car = 1'b0; step(6);
      chk("R3 stop on carrier drop", count, 40);
      end_tx(40, "R9");
   endtask

   task automatic t_collision();
      do_clear(); tx = 1'b1; car = 1'b1; step(25); col = 1'b1; step(10);
      chk("R4 stop on collision", count, 25);
      end_tx(25, "R4");
      do_clear(); tx = 1'b1; car = 1'b1; col = 1'b1; step(10);
      chk("R4 simultaneous", count, 0);
      end_tx(0, "R4");
   endtask

   task automatic t_no_restart();
      do_clear(); tx = 1'b1; car = 1'b1; step(15); car = 1'b0; step(5);
      car = 1'b1; step(20);
      chk("R5 no restart", count, 15);
      end_tx(15, "R5");
   endtask

   task automatic t_tick_gate();
      do_clear(); tx = 1'b1; tick = 1'b0; step(2);
      car = 1'b1;
      for (int i = 0; i < 40; i++) begin
         tick = ~tick;
         if (i == 30) car = 1'b0;
         step(1);
      end
      tick = 1'b1; step(3);
      chk("R11 tick gating", count, 15);
      end_tx(15, "R11");
   endtask

   task automatic t_saturate();
      do_clear(); tx = 1'b1; car = 1'b1; step(1100);
      chk("R6 saturate", count, 1023);
      step(5);
      chk("R6 no wrap", count, 1023);
      end_tx(1023, "R6");
   endtask

   task automatic t_clear_prio();
      do_clear(); tx = 1'b1; car = 1'b1; step(50);
      chk("R2 running", count, 48);
      clr = 1'b1; step(1); clr = 1'b0;
      chk("R7 clear beats tick", count, 0);
      step(10);
      chk("R7 resumes", count, 10);
      car = 1'b0; step(4);
      end_tx(12, "R7");
   endtask

   task automatic t_hold();
      step(20);
      chk("R8 held after tx", count, 12);
      tx = 1'b1; step(6);
      chk("R8 held new tx", count, 12);
      end_tx(12, "R8");
      do_clear();
      chk("R8 clear only", count, 0);
   endtask

   initial begin : wdog
      #(CLK_PERIOD * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      step(3);
      t_reset();
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_no_tx();
      t_carrier_drop();
      t_collision();
      t_no_restart();
      t_tick_gate();
      t_saturate();
      t_clear_prio();
      t_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule